// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Bank

This block is the memory-mapped control and status front end of a sixteen-channel DMA engine. Software programs each channel through a private group of four registers: word start address, line length, line count and control. A set of shared registers holds the per-channel line stride, a stop command, the interrupt status and enable masks, and a two-bit-per-channel loop enable. The block drives each channel's configuration onto wide flattened output buses for the transfer datapath. It also emits single-cycle start and stop strobes.

A write to a channel's address register is the launch command. It raises that channel's start strobe for exactly one cycle. The datapath reports the end of a transfer with a one-cycle completion pulse per channel. These pulses are latched into the status register, masked by the enable register and merged into a single interrupt line. Software clears status bits by writing ones to them.

Top module: `dma_regbank`

## Requirements
- R1: After reset every register reads zero, and `irq_o`, `start_o` and `stop_o` are low.
- R2: Channel n's registers sit at byte offset n*0x10. The word address is at +0x0 and holds 30 bits. The line length is at +0x4 and the line count at +0x8, each holding 16 bits. Reads return the stored value zero-extended, and upper write bits are dropped.
- R3: A write to channel n's address register raises `start_o[n]` for one cycle, in the cycle after the write. Writes to any other register leave `start_o` low.
- R4: The control register at channel n's +0xC stores 6 bits. Bits 3:0 are a channel tag that is only stored. Bit 4 drives `burst_o[n]`, and bit 5 drives `dir_o[n]`, where 1 means memory to device and 0 means device to memory.
- R5: Channel n's 16-bit stride register is at 0x100 + 4*n and drives its slice of `cfg_stride_o`.
- R6: Writing a 1 to bit n at 0x140 raises `stop_o[n]` for one cycle, in the cycle after the write. That offset always reads zero.
- R7: Status at 0x144 sets bit n on `done_i[n]` and clears bit n when a one is written to it. A completion pulse in the same cycle as the clear wins, and the bit stays set.
- R8: Enable at 0x148 is a per-channel mask. `irq_o` is high exactly when some channel has both its status bit and its enable bit set.
- R9: Loop control at 0x150 stores bits n and n+16 for each channel and reads back as written. `loop_o[n]` is high only when both bits are set.
- R10: Reads of unmapped or unaligned offsets return zero. Writes to them change no register and raise no strobe.
- R11: `rdata` is registered. It takes the value addressed in the cycle when `rd_en` is high, before any same-cycle write takes effect, and holds while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| done_i | input | NCH | Per-channel completion pulses |
| irq_o | output | 1 | Combined interrupt |
| start_o | output | NCH | Per-channel launch strobes |
| stop_o | output | NCH | Per-channel stop strobes |
| cfg_addr_o | output | NCH*ADR_W | Word start address per channel |
| cfg_xlen_o | output | NCH*LEN_W | Line length per channel |
| cfg_ylen_o | output | NCH*LEN_W | Line count per channel |
| cfg_stride_o | output | NCH*LEN_W | Line stride per channel |
| burst_o | output | NCH | Burst mode per channel |
| dir_o | output | NCH | Direction per channel |
| loop_o | output | NCH | Loop enable per channel |

## Verification
Some properties are checked on every cycle. A start or stop strobe may appear only after the matching write. A completion pulse always leaves its status bit set. A clear without a competing pulse empties the bit. Control-bit writes reach the burst and direction outputs. The interrupt line may rise only after a completion or an enable write. Other behaviour can only be shown by the bench's scenarios. These include the width masking on read-back and the silence of unmapped offsets. They also cover the registered read timing and the interplay of status, enable and interrupt across a sequence of accesses.

// File: rtl/dma_regbank.sv
module dma_regbank #(
  parameter int NCH   = 16,
  parameter int AW    = 12,
  parameter int ADR_W = 30,
  parameter int LEN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  input  logic [NCH-1:0]         done_i,
  output logic                   irq_o,
  output logic [NCH-1:0]         start_o,
  output logic [NCH-1:0]         stop_o,
  output logic [NCH*ADR_W-1:0]   cfg_addr_o,
  output logic [NCH*LEN_W-1:0]   cfg_xlen_o,
  output logic [NCH*LEN_W-1:0]   cfg_ylen_o,
  output logic [NCH*LEN_W-1:0]   cfg_stride_o,
  output logic [NCH-1:0]         burst_o,
  output logic [NCH-1:0]         dir_o,
  output logic [NCH-1:0]         loop_o
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CTW = 6;
  localparam logic [AW-1:0] GRP_END  = AW'(NCH * 16);
  localparam logic [AW-1:0] STR_BASE = AW'('h100);
  localparam logic [AW-1:0] STR_END  = AW'('h100 + NCH * 4);
  localparam logic [AW-1:0] A_INV    = AW'('h140);
  localparam logic [AW-1:0] A_STS    = AW'('h144);
  localparam logic [AW-1:0] A_EN     = AW'('h148);
  localparam logic [AW-1:0] A_LOOP   = AW'('h150);

  logic [ADR_W-1:0] r_addr   [NCH];
  logic [LEN_W-1:0] r_xlen   [NCH];
  logic [LEN_W-1:0] r_ylen   [NCH];
  logic [LEN_W-1:0] r_stride [NCH];
  logic [CTW-1:0]   r_ctrl   [NCH];
  logic [NCH-1:0]   sts, en, loop_lo, loop_hi;

  logic           aligned, in_grp, in_str;
  logic [CHW-1:0] grp_ch, str_ch;
  logic [1:0]     grp_reg;
  logic           hit_inv, hit_sts, hit_en, hit_loop;
  logic [31:0]    rd_mux;

  assign aligned  = (addr[1:0] == 2'b00);
  assign in_grp   = aligned && (addr < GRP_END);
  assign in_str   = aligned && (addr >= STR_BASE) && (addr < STR_END);
  assign grp_ch   = addr[CHW+3:4];
  assign grp_reg  = addr[3:2];
  assign str_ch   = addr[CHW+1:2];
  assign hit_inv  = (addr == A_INV);
  assign hit_sts  = (addr == A_STS);
  assign hit_en   = (addr == A_EN);
  assign hit_loop = (addr == A_LOOP);

  assign irq_o  = |(sts & en);
  assign loop_o = loop_lo & loop_hi;

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      logic wr_grp, wr_str;
      assign wr_grp = wr_en && in_grp && (grp_ch == CHW'(i));
      assign wr_str = wr_en && in_str && (str_ch == CHW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r_addr[i]   <= '0;
          r_xlen[i]   <= '0;
          r_ylen[i]   <= '0;
          r_ctrl[i]   <= '0;
          r_stride[i] <= '0;
          start_o[i]  <= 1'b0;
        end else begin
          start_o[i] <= wr_grp && (grp_reg == 2'd0);
          if (wr_grp) begin
            case (grp_reg)
              2'd0:    r_addr[i] <= wdata[ADR_W-1:0];
              2'd1:    r_xlen[i] <= wdata[LEN_W-1:0];
              2'd2:    r_ylen[i] <= wdata[LEN_W-1:0];
              default: r_ctrl[i] <= wdata[CTW-1:0];
            endcase
          end
          if (wr_str) r_stride[i] <= wdata[LEN_W-1:0];
        end
      end

      assign cfg_addr_o[i*ADR_W +: ADR_W]   = r_addr[i];
      assign cfg_xlen_o[i*LEN_W +: LEN_W]   = r_xlen[i];
      assign cfg_ylen_o[i*LEN_W +: LEN_W]   = r_ylen[i];
      assign cfg_stride_o[i*LEN_W +: LEN_W] = r_stride[i];
      assign burst_o[i] = r_ctrl[i][4];
      assign dir_o[i]   = r_ctrl[i][5];

      assert_start_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o[i] |-> $past(wr_en && addr == AW'(i * 16)));
      assert_ctrl_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(i * 16 + 12)) |=>
          (burst_o[i] == $past(wdata[4]) && dir_o[i] == $past(wdata[5])));
      assert_stop_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o[i] |-> $past(wr_en && addr == A_INV && wdata[i]));
      assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_i[i] |=> sts[i]);
      assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STS && wdata[i] && !done_i[i]) |=> !sts[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts     <= '0;
      en      <= '0;
      loop_lo <= '0;
      loop_hi <= '0;
      stop_o  <= '0;
    end else begin
      stop_o <= (wr_en && hit_inv) ? wdata[NCH-1:0] : '0;
      sts    <= (sts & ~((wr_en && hit_sts) ? wdata[NCH-1:0] : '0)) | done_i;
      if (wr_en && hit_en) en <= wdata[NCH-1:0];
      if (wr_en && hit_loop) begin
        loop_lo <= wdata[NCH-1:0];
        loop_hi <= wdata[16 +: NCH];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_grp) begin
      case (grp_reg)
        2'd0:    rd_mux = 32'(r_addr[grp_ch]);
        2'd1:    rd_mux = 32'(r_xlen[grp_ch]);
        2'd2:    rd_mux = 32'(r_ylen[grp_ch]);
        default: rd_mux = 32'(r_ctrl[grp_ch]);
      endcase
    end else if (in_str)   rd_mux = 32'(r_stride[str_ch]);
    else if (hit_sts)      rd_mux = 32'(sts);
    else if (hit_en)       rd_mux = 32'(en);
    else if (hit_loop)     rd_mux = 32'(loop_lo) | (32'(loop_hi) << 16);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(|done_i) || $past(wr_en && addr == A_EN)));
endmodule

// File: tb/tb_dma_regbank.sv
module tb_dma_regbank;
  localparam int NCH = 16, AW = 12, ADR_W = 30, LEN_W = 16;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  logic [NCH-1:0] done_i = '0, start_o, stop_o, burst_o, dir_o, loop_o;
  logic irq_o;
  logic [NCH*ADR_W-1:0] cfg_addr_o;
  logic [NCH*LEN_W-1:0] cfg_xlen_o, cfg_ylen_o, cfg_stride_o;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  dma_regbank #(.NCH(NCH), .AW(AW), .ADR_W(ADR_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done_i(done_i), .irq_o(irq_o),
    .start_o(start_o), .stop_o(stop_o), .cfg_addr_o(cfg_addr_o),
    .cfg_xlen_o(cfg_xlen_o), .cfg_ylen_o(cfg_ylen_o), .cfg_stride_o(cfg_stride_o),
    .burst_o(burst_o), .dir_o(dir_o), .loop_o(loop_o));

  localparam int NV = 10;
  localparam logic [AW-1:0] VA [NV] = '{12'h000, 12'h054, 12'h0F8, 12'h03C, 12'h108,
                                        12'h13C, 12'h150, 12'h140, 12'h14C, 12'h1F0};
  localparam logic [31:0] VW [NV] = '{32'hFFFF_FFFF, 32'h1234_ABCD, 32'hFFFF_0007,
                                      32'hFFFF_FFE5, 32'h0001_0040, 32'h0000_ABCD,
                                      32'h0003_0001, 32'h0000_0000, 32'hFFFF_FFFF,
                                      32'hFFFF_FFFF};
  localparam logic [31:0] VE [NV] = '{32'h3FFF_FFFF, 32'h0000_ABCD, 32'h0000_0007,
                                      32'h0000_0025, 32'h0000_0040, 32'h0000_ABCD,
                                      32'h0003_0001, 32'h0, 32'h0, 32'h0};
  localparam string VR [NV] = '{"R2", "R2", "R2", "R4", "R5", "R5", "R9", "R6",
                                "R10", "R10"};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    check("R1 start", 32'(start_o), 0);
    rd(12'h000, rv); check("R1 addr0", rv, 0);
    rd(12'h144, rv); check("R1 status", rv, 0);
    rd(12'h150, rv); check("R1 loop", rv, 0);

    for (int k = 0; k < NV; k++) begin
      wr(VA[k], VW[k]);
      rd(VA[k], rv);
      check(VR[k], rv, VE[k]);
    end
    check("R2 cfg_addr ch0", 32'(cfg_addr_o[ADR_W-1:0]), 32'h3FFF_FFFF);
    check("R4 dir ch3", 32'(dir_o[3]), 1);
    check("R4 burst ch3", 32'(burst_o[3]), 0);
    check("R5 stride ch2", 32'(cfg_stride_o[2*LEN_W +: LEN_W]), 32'h40);
    check("R9 loop_o", 32'(loop_o), 32'h0001);
    rd(12'h148, rv); check("R10 enable untouched", rv, 0);
    rd(12'h000, rv); check("R10 ch0 untouched", rv, 32'h3FFF_FFFF);

    // R3 launch strobe
    wr(12'h050, 32'h100);
    check("R3 start pulse", 32'(start_o), 32'h0020);
    @(negedge clk); check("R3 start one cycle", 32'(start_o), 0);
    wr(12'h054, 32'h5);
    check("R3 no start on xlen", 32'(start_o), 0);
    wr(12'h1F0, 32'hFFFF);
    check("R10 no start", 32'(start_o), 0);
    wr(12'h07C, 32'h10);
    check("R4 burst ch7", 32'(burst_o[7]), 1);
    check("R4 dir ch7", 32'(dir_o[7]), 0);

    // R6 stop strobe
    wr(12'h140, 32'h0000_8004);
    check("R6 stop pulse", 32'(stop_o), 32'h8004);
    @(negedge clk); check("R6 stop one cycle", 32'(stop_o), 0);

    // R7 status
    @(negedge clk); done_i = 16'h0004;
    @(negedge clk); done_i = 0;
    rd(12'h144, rv); check("R7 done sets", rv, 32'h4);
    check("R8 masked irq low", 32'(irq_o), 0);
    wr(12'h144, 32'h4);
    rd(12'h144, rv); check("R7 w1c", rv, 0);
    @(negedge clk); wr_en = 1; addr = 12'h144; wdata = 32'h200; done_i = 16'h0200;
    @(negedge clk); wr_en = 0; done_i = 0;
    rd(12'h144, rv); check("R7 set wins", rv, 32'h200);

    // R8 interrupt
    wr(12'h148, 32'h200);
    check("R8 irq high", 32'(irq_o), 1);
    wr(12'h148, 32'h100);
    check("R8 other enable", 32'(irq_o), 0);
    wr(12'h148, 32'h200);
    wr(12'h144, 32'h200);
    check("R8 irq cleared", 32'(irq_o), 0);

    // R11 registered read holds
    rd(12'h108, rv);
    wr(12'h108, 32'h77);
    check("R11 rdata holds", rdata, 32'h40);
    @(negedge clk); rd_en = 1; addr = 12'h108; wr_en = 1; wdata = 32'h99;
    @(negedge clk); rd_en = 0; wr_en = 0;
    check("R11 old value read", rdata, 32'h77);

    finish_run();
  end
endmodule